// File: doc/BRIEF.md
# Memory Protection Permission Checker

This block decides, for one memory access, what the current execution mode may do at a 32-bit address. It takes the address, the kind of access (load, store or instruction fetch), a privilege flag, a global protection-enable flag and a flattened table of protection regions. It returns read, write and execute permission bits, a single grant bit for the requested access kind, a hit flag, a miss flag and the number of the region that supplied the answer.

Each region is described by three words: a base address, a size word and an attribute word. Where regions overlap, the higher-numbered region wins. Two address windows in the upper system space get fixed treatment. The private peripheral window always uses the default memory map. Everything from 0xE0000000 upward is never executable through a region. The result can be taken straight from the logic or through one output register, chosen by a parameter.

Top module: `mpu_perm_check`

## Requirements
- R1: When `mpu_en` is 0, no region is consulted. A privileged access gets read, write and execute, and a user access gets nothing. `hit` and `miss` are 0 and `rgn_idx` is 0.
- R2: When `addr[31:20]` is 12'hE00, the R1 default-map result applies even with `mpu_en` at 1, whatever the region table holds.
- R3: Region n matches when bit 0 of its size word is 1 and the address lies in the window of 2^(S+1) bytes that contains the base address and is aligned to that size. S is bits [5:1] of the size word. A region whose bit 0 is 0 never matches.
- R4: When several enabled regions match, the highest-numbered one wins. Its number appears on `rgn_idx` and `hit` is 1.
- R5: On a hit, bits [10:8] of the winning region's attribute word give the access rights. 000 gives none. 001 gives privileged read/write and user none. 010 gives privileged read/write and user read. 011 gives read/write in both modes. 101 gives privileged read and user none. 110 gives read in both modes. 100 and 111 give none.
- R6: On a hit, execute is granted only when the R5 decode gives read to the current mode and bit 12 of the attribute word is 0.
- R7: On a hit at an address with `addr[31:29]` equal to 3'b111, execute is never granted, even when bit 12 is 0.
- R8: With protection on, outside the R2 window, and no enabled region matching, `miss` is 1, `hit` is 0 and all permissions are 0.
- R9: `grant` reports the permission for `acc_type`: 2'b00 read, 2'b01 write, 2'b10 execute. The code 2'b11 always gives 0.
- R10: With `REG_OUT` = 1, all outputs show the result for the inputs present at the previous rising clock edge. While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| addr | input | 32 | Address being checked |
| acc_type | input | 2 | Access kind: 00 read, 01 write, 10 execute, 11 none |
| is_priv | input | 1 | 1 for a privileged access, 0 for a user access |
| mpu_en | input | 1 | Global protection enable |
| rgn_base | input | NUM_REGIONS*32 | Base address of each region; region n in bits [32n+31:32n] |
| rgn_size | input | NUM_REGIONS*6 | Size word of each region: bit 0 enable, bits [5:1] size code |
| rgn_attr | input | NUM_REGIONS*16 | Attribute word of each region: bits [10:8] access code, bit 12 no-execute |
| perm_r | output | 1 | Read permitted |
| perm_w | output | 1 | Write permitted |
| perm_x | output | 1 | Execute permitted |
| grant | output | 1 | Permission for the access kind on `acc_type` |
| hit | output | 1 | An enabled region supplied the result |
| miss | output | 1 | Protection was consulted and no region matched |
| rgn_idx | output | IDX_W | Number of the winning region, 0 when there is none |

## Verification
The overlap that matters is a single access at which region priority and the forced no-execute rule for system space both apply. A catch-all low-priority region and a higher-numbered region both cover 0xE0100000, and both have bit 12 clear. The expected result is the higher region's number with execute still withheld. A second coincidence puts a PPB address under that same catch-all region, where the default-map bypass must override a region that matches. Each case is judged field by field against a reference model in the bench, one cycle after the inputs are driven.

// File: rtl/mpu_chk_pkg.sv
package mpu_chk_pkg;

   localparam int ADDR_W      = 32;
   localparam int SIZE_W      = 6;
   localparam int ATTR_W      = 16;
   localparam int AP_LSB      = 8;
   localparam int XN_BIT      = 12;
   localparam logic [11:0] PPB_TAG = 12'hE00;
   localparam logic [2:0]  SYS_TAG = 3'b111;

   typedef enum logic [1:0] {
      ACC_READ  = 2'b00,
      ACC_WRITE = 2'b01,
      ACC_EXEC  = 2'b10,
      ACC_NONE  = 2'b11
   } acc_e;

   typedef struct packed {
      logic r;
      logic w;
      logic x;
   } perm_t;

   // Rights for one mode from the three-bit access code (R5)
   function automatic perm_t ap_decode(input logic [2:0] ap, input logic priv);
      perm_t p;
      p = '0;
      case (ap)
         3'b001:  begin p.r = priv; p.w = priv; end
         3'b010:  begin p.r = 1'b1; p.w = priv; end
         3'b011:  begin p.r = 1'b1; p.w = 1'b1; end
         3'b101:  begin p.r = priv; end
         3'b110:  begin p.r = 1'b1; end
         default: p = '0;
      endcase
      return p;
   endfunction

endpackage

// File: rtl/mpu_region_match.sv
module mpu_region_match
   import mpu_chk_pkg::*;
(
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] base,
   input  logic [SIZE_W-1:0] size_word,
   output logic              match
);
   logic [5:0]        shamt;
   logic [ADDR_W:0]   span;
   logic [ADDR_W:0]   low_mask;

   always_comb begin
      shamt    = {1'b0, size_word[5:1]} + 6'd1;
      span     = {{ADDR_W{1'b0}}, 1'b1} << shamt;
      low_mask = span - {{ADDR_W{1'b0}}, 1'b1};
      match    = size_word[0] &&
                 (((addr ^ base) & ~low_mask[ADDR_W-1:0]) == '0);
   end
endmodule

// File: rtl/mpu_prio_pick.sv
module mpu_prio_pick #(
   parameter int N     = 8,
   parameter int IDX_W = 3
) (
   input  logic [N-1:0]     req,
   output logic             found,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      // later (higher) entries overwrite earlier ones: highest wins
      for (int i = 0; i < N; i++) begin
         if (req[i]) begin
            found = 1'b1;
            idx   = i[IDX_W-1:0];
         end
      end
   end
endmodule

// File: rtl/mpu_perm_decode.sv
module mpu_perm_decode
   import mpu_chk_pkg::*;
(
   input  logic [ATTR_W-1:0] attr,
   input  logic              priv,
   input  logic              sys_space,
   output perm_t             perm
);
   perm_t base_p;

   always_comb begin
      base_p = ap_decode(attr[AP_LSB +: 3], priv);
      perm.r = base_p.r;
      perm.w = base_p.w;
      perm.x = base_p.r && !attr[XN_BIT] && !sys_space;
   end
endmodule

// File: rtl/mpu_perm_check.sv
module mpu_perm_check
   import mpu_chk_pkg::*;
#(
   parameter int NUM_REGIONS = 8,
   parameter bit REG_OUT     = 1'b1,
   localparam int IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [31:0]                   addr,
   input  logic [1:0]                    acc_type,
   input  logic                          is_priv,
   input  logic                          mpu_en,
   input  logic [NUM_REGIONS*32-1:0]     rgn_base,
   input  logic [NUM_REGIONS*6-1:0]      rgn_size,
   input  logic [NUM_REGIONS*16-1:0]     rgn_attr,
   output logic                          perm_r,
   output logic                          perm_w,
   output logic                          perm_x,
   output logic                          grant,
   output logic                          hit,
   output logic                          miss,
   output logic [IDX_W-1:0]              rgn_idx
);
   generate
      if (NUM_REGIONS < 1 || NUM_REGIONS > 256) begin : g_bad_count
         $error("mpu_perm_check: NUM_REGIONS must lie in 1..256");
      end
   endgenerate

   logic [NUM_REGIONS-1:0] c_match;
   logic                   c_found;
   logic [IDX_W-1:0]       c_pick;
   logic [ATTR_W-1:0]      c_attr;
   logic                   c_bypass;
   logic                   c_sys;
   perm_t                  c_region_perm;
   perm_t                  c_perm;
   logic                   c_hit;
   logic                   c_miss;
   logic [IDX_W-1:0]       c_idx;
   logic                   c_grant;

   genvar g;
   generate
      for (g = 0; g < NUM_REGIONS; g++) begin : g_rgn
         mpu_region_match u_match (
            .addr      (addr),
            .base      (rgn_base[g*ADDR_W +: ADDR_W]),
            .size_word (rgn_size[g*SIZE_W +: SIZE_W]),
            .match     (c_match[g])
         );
      end
   endgenerate

   mpu_prio_pick #(.N(NUM_REGIONS), .IDX_W(IDX_W)) u_pick (
      .req   (c_match),
      .found (c_found),
      .idx   (c_pick)
   );

   assign c_attr   = rgn_attr[c_pick*ATTR_W +: ATTR_W];
   assign c_bypass = !mpu_en || (addr[31:20] == PPB_TAG);
   assign c_sys    = (addr[31:29] == SYS_TAG);

   mpu_perm_decode u_dec (
      .attr      (c_attr),
      .priv      (is_priv),
      .sys_space (c_sys),
      .perm      (c_region_perm)
   );

   always_comb begin
      c_hit  = 1'b0;
      c_miss = 1'b0;
      c_idx  = '0;
      c_perm = '0;
      if (c_bypass) begin
         c_perm = is_priv ? 3'b111 : 3'b000;
      end else if (c_found) begin
         c_hit  = 1'b1;
         c_idx  = c_pick;
         c_perm = c_region_perm;
      end else begin
         c_miss = 1'b1;
      end
      case (acc_type)
         ACC_READ:  c_grant = c_perm.r;
         ACC_WRITE: c_grant = c_perm.w;
         ACC_EXEC:  c_grant = c_perm.x;
         default:   c_grant = 1'b0;
      endcase
   end

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               perm_r  <= 1'b0;
               perm_w  <= 1'b0;
               perm_x  <= 1'b0;
               grant   <= 1'b0;
               hit     <= 1'b0;
               miss    <= 1'b0;
               rgn_idx <= '0;
            end else begin
               perm_r  <= c_perm.r;
               perm_w  <= c_perm.w;
               perm_x  <= c_perm.x;
               grant   <= c_grant;
               hit     <= c_hit;
               miss    <= c_miss;
               rgn_idx <= c_idx;
            end
         end
      end else begin : g_comb
         assign perm_r  = c_perm.r;
         assign perm_w  = c_perm.w;
         assign perm_x  = c_perm.x;
         assign grant   = c_grant;
         assign hit     = c_hit;
         assign miss    = c_miss;
         assign rgn_idx = c_idx;
      end
   endgenerate
endmodule

// File: rtl/mpu_perm_check_sva.sv
module mpu_perm_check_sva (
   input logic        clk,
   input logic        rst_n,
   input logic [31:0] addr,
   input logic [1:0]  acc_type,
   input logic        is_priv,
   input logic        mpu_en,
   input logic        c_hit,
   input logic        c_miss,
   input logic [2:0]  c_perm,
   input logic        c_grant
);
   // c_perm bit order: [2] read, [1] write, [0] execute

   a_r1_disabled_default: assert property (@(posedge clk) disable iff (!rst_n)
      !mpu_en |-> (!c_hit && !c_miss && c_perm == (is_priv ? 3'b111 : 3'b000)));

   a_r2_ppb_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      (mpu_en && addr[31:20] == 12'hE00) |->
         (!c_hit && !c_miss && c_perm == (is_priv ? 3'b111 : 3'b000)));

   a_r5_write_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
      (c_hit && c_perm[1]) |-> c_perm[2]);

   a_r6_exec_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
      (c_hit && c_perm[0]) |-> c_perm[2]);

   a_r7_system_no_exec: assert property (@(posedge clk) disable iff (!rst_n)
      (c_hit && addr[31:29] == 3'b111) |-> !c_perm[0]);

   a_r8_miss_empty: assert property (@(posedge clk) disable iff (!rst_n)
      c_miss |-> (c_perm == 3'b000 && !c_hit));

   a_r9_none_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_type == 2'b11) |-> !c_grant);
endmodule

bind mpu_perm_check mpu_perm_check_sva u_sva (
   .clk      (clk),
   .rst_n    (rst_n),
   .addr     (addr),
   .acc_type (acc_type),
   .is_priv  (is_priv),
   .mpu_en   (mpu_en),
   .c_hit    (c_hit),
   .c_miss   (c_miss),
   .c_perm   (c_perm),
   .c_grant  (c_grant)
);

// File: tb/test_mpu_perm_check.sv
`timescale 1ns/1ps
module test_mpu_perm_check;
   localparam int NR    = 8;
   localparam int IDX_W = 3;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic [31:0]          addr = '0;
   logic [1:0]           acc_type = '0;
   logic                 is_priv = 1'b0;
   logic                 mpu_en = 1'b0;
   logic [NR*32-1:0]     rgn_base;
   logic [NR*6-1:0]      rgn_size;
   logic [NR*16-1:0]     rgn_attr;
   logic                 perm_r, perm_w, perm_x, grant, hit, miss;
   logic [IDX_W-1:0]     rgn_idx;

   logic [31:0] st_base [NR];
   logic [5:0]  st_size [NR];
   logic [15:0] st_attr [NR];
   logic [31:0] dr_base [NR];
   logic [5:0]  dr_size [NR];
   logic [15:0] dr_attr [NR];

   typedef struct { logic [8:0] v; string tag; } exp_t;
   exp_t sb_q[$];

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   always_comb begin
      for (int i = 0; i < NR; i++) begin
         rgn_base[i*32 +: 32] = dr_base[i];
         rgn_size[i*6 +: 6]   = dr_size[i];
         rgn_attr[i*16 +: 16] = dr_attr[i];
      end
   end

   mpu_perm_check #(.NUM_REGIONS(NR), .REG_OUT(1'b1)) i_mpu_perm_check (
      .clk(clk), .rst_n(rst_n), .addr(addr), .acc_type(acc_type),
      .is_priv(is_priv), .mpu_en(mpu_en), .rgn_base(rgn_base),
      .rgn_size(rgn_size), .rgn_attr(rgn_attr), .perm_r(perm_r),
      .perm_w(perm_w), .perm_x(perm_x), .grant(grant), .hit(hit),
      .miss(miss), .rgn_idx(rgn_idx)
   );

   // reference model: {r,w,x,grant,hit,miss,idx[2:0]}
   function automatic logic [8:0] model(input logic [31:0] a, input logic [1:0] t,
                                        input logic p, input logic e);
      logic r, w, x, g, h, m;
      logic [2:0] ix;
      logic [2:0] ap;
      int sh;
      r = 0; w = 0; x = 0; h = 0; m = 0; ix = 0;
      if (!e || a[31:20] == 12'hE00) begin
         r = p; w = p; x = p;
      end else begin
         for (int i = NR - 1; i >= 0; i--) begin
            sh = int'(dr_size[i][5:1]) + 1;
            if (!h && dr_size[i][0] &&
                ((64'(a) >> sh) == (64'(dr_base[i]) >> sh))) begin
               h  = 1;
               ix = 3'(i);
            end
         end
         if (h) begin
            ap = dr_attr[ix][10:8];
            if (ap == 3'b011 || ap == 3'b110 || ap == 3'b010) r = 1;
            if ((ap == 3'b001 || ap == 3'b101) && p) r = 1;
            if (ap == 3'b011) w = 1;
            if ((ap == 3'b001 || ap == 3'b010) && p) w = 1;
            x = r && !dr_attr[ix][12] && (a[31:29] != 3'b111);
         end else begin
            m = 1;
         end
      end
      g = (t == 2'b00) ? r : (t == 2'b01) ? w : (t == 2'b10) ? x : 1'b0;
      return {r, w, x, g, h, m, ix};
   endfunction

   task automatic apply(input logic [31:0] a, input logic [1:0] t,
                        input logic p, input logic e, input string tag);
      exp_t it;
      @(negedge clk);
      for (int i = 0; i < NR; i++) begin
         dr_base[i] = st_base[i];
         dr_size[i] = st_size[i];
         dr_attr[i] = st_attr[i];
      end
      addr = a; acc_type = t; is_priv = p; mpu_en = e;
      it.v   = model(a, t, p, e);
      it.tag = tag;
      sb_q.push_back(it);
   endtask

   // monitor: R10, outputs one cycle after the inputs are driven
   always @(posedge clk) begin
      #1;
      if (sb_q.size() > 0) begin
         exp_t it;
         logic [8:0] act;
         it  = sb_q.pop_front();
         act = {perm_r, perm_w, perm_x, grant, hit, miss, rgn_idx};
         n_checks++;
         if (act !== it.v) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b (r w x grant hit miss idx)",
                     it.tag, act, it.v);
         end
      end
   end

   task automatic clear_table();
      for (int i = 0; i < NR; i++) begin
         st_base[i] = '0; st_size[i] = '0; st_attr[i] = '0;
      end
   endtask

   initial begin
      clear_table();
      for (int i = 0; i < NR; i++) begin
         dr_base[i] = '0; dr_size[i] = '0; dr_attr[i] = '0;
      end
      // drive non-zero inputs during reset; R10 says outputs stay 0
      addr = 32'h0000_1000; is_priv = 1'b1; mpu_en = 1'b0;
      repeat (3) @(negedge clk);
      n_checks++;
      if ({perm_r, perm_w, perm_x, grant, hit, miss, rgn_idx} !== 9'b0) begin
         n_fail++;
         $display("FAIL R10 reset: actual %b expected %b",
                  {perm_r, perm_w, perm_x, grant, hit, miss, rgn_idx}, 9'b0);
      end
      rst_n = 1'b1;

      // region 0: everything, full access, executable
      st_base[0] = 32'h0; st_size[0] = {5'd31, 1'b1}; st_attr[0] = 16'h0300;
      // region 3: 4 KiB at 0x2000_0000, read-only both
      st_base[3] = 32'h2000_0000; st_size[3] = {5'd11, 1'b1}; st_attr[3] = 16'h0600;
      // region 5: disabled, same window, full access
      st_base[5] = 32'h2000_0000; st_size[5] = {5'd11, 1'b0}; st_attr[5] = 16'h0300;

      apply(32'h2000_0010, 2'b01, 1'b1, 1'b0, "R1 disabled priv write");
      apply(32'h2000_0010, 2'b10, 1'b1, 1'b0, "R1 disabled priv exec");
      apply(32'h2000_0010, 2'b00, 1'b0, 1'b0, "R1 disabled user read");
      apply(32'hE000_0100, 2'b10, 1'b1, 1'b1, "R2 ppb priv exec over region");
      apply(32'hE00F_FFFC, 2'b00, 1'b0, 1'b1, "R2 ppb user read");
      apply(32'h2000_0010, 2'b01, 1'b0, 1'b1, "R4 overlap user write ro");
      apply(32'h2000_0FFC, 2'b00, 1'b0, 1'b1, "R3 last byte of window");
      apply(32'h2000_1000, 2'b01, 1'b0, 1'b1, "R3 just above window");
      apply(32'h1FFF_FFFC, 2'b01, 1'b1, 1'b1, "R3 just below window");
      apply(32'h2000_0010, 2'b10, 1'b1, 1'b1, "R6 ro region exec");
      apply(32'hE010_0000, 2'b10, 1'b1, 1'b1, "R7 system space exec");
      apply(32'hFFFF_FFF0, 2'b00, 1'b1, 1'b1, "R7 system space read");
      apply(32'h2000_0010, 2'b11, 1'b1, 1'b1, "R9 access code none");

      // R7 with priority: higher region over system space, no XN bit
      st_base[6] = 32'hE010_0000; st_size[6] = {5'd19, 1'b1}; st_attr[6] = 16'h0300;
      apply(32'hE010_0400, 2'b10, 1'b1, 1'b1, "R7 R4 high region system exec");
      apply(32'hE010_0400, 2'b01, 1'b0, 1'b1, "R4 high region user write");

      // R8 miss: drop the catch-all region
      st_size[0] = 6'd0;
      apply(32'h4000_0000, 2'b00, 1'b1, 1'b1, "R8 miss priv read");
      apply(32'h4000_0000, 2'b11, 1'b0, 1'b1, "R8 miss user none");
      apply(32'h2000_0010, 2'b00, 1'b0, 1'b1, "R3 disabled region ignored");

      // R5 / R6 sweep of access codes in region 2
      st_base[2] = 32'h1000_0000; st_size[2] = {5'd11, 1'b1};
      for (int c = 0; c < 8; c++) begin
         for (int pv = 0; pv < 2; pv++) begin
            st_attr[2] = {3'b000, 1'b0, 1'b0, 3'(c), 8'h00};
            apply(32'h1000_0800, 2'b00, 1'(pv), 1'b1, $sformatf("R5 code %0d priv %0d", c, pv));
         end
      end
      for (int pv = 0; pv < 2; pv++) begin
         st_attr[2] = 16'h1300;
         apply(32'h1000_0800, 2'b10, 1'(pv), 1'b1, $sformatf("R6 xn bit priv %0d", pv));
         st_attr[2] = 16'h0300;
         apply(32'h1000_0800, 2'b10, 1'(pv), 1'b1, $sformatf("R6 exec allowed priv %0d", pv));
      end
      st_attr[2] = 16'h0600;
      apply(32'h1000_0800, 2'b01, 1'b1, 1'b1, "R9 write on ro");

      repeat (3) @(posedge clk);
      #1;
      if (sb_q.size() != 0) begin
         n_checks++; n_fail++;
         $display("FAIL R10 scoreboard: actual %0d pending expected 0", sb_q.size());
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule